// File: doc/BRIEF.md
# Cascadable Up/Down Count Stage with Snapshot Latch

This block is one stage of a wide up/down counter. A lower stage feeds it two active-low pulse lines, one asking for an increment and one for a decrement. Both lines idle high, and the count moves when a pulse ends, that is on the rising edge of the line. The stage makes its own active-low carry and borrow pulses, so more stages can be chained to widen the count in steps of `CNT_W` bits. Every control input is asynchronous to the system clock. Each one passes through a synchronizer before any edge is detected.

The count reaches the data bus through a snapshot latch. The latch is transparent while the strobe is high and freezes when the strobe goes low. If the strobe falls in the middle of a count pulse, the capture waits until that pulse has been counted, so a reader never sees a value caught half-way through an update. A separate clear input holds the count at zero. The data bus is modelled as a value plus an enable flag that stands in for a tristate pad.

Top module: `ext_updown_stage`

## Requirements
- R1: A rising edge on `cnt_up_n` while `cnt_dn_n` is high (before and at the edge) and `cnt_clr` is low adds one to the count, wrapping modulo 2^CNT_W. The new value is visible on a transparent `data_out` within 5 clock cycles of the input edge.
- R2: A rising edge on `cnt_dn_n` while `cnt_up_n` is high and `cnt_clr` is low subtracts one from the count, wrapping modulo 2^CNT_W.
- R3: While both count lines are low, `collide_err` is high (within 4 cycles), and the count does not change. Releasing both lines together counts nothing, and `collide_err` returns low.
- R4: An up pulse that starts while the count is all ones drives `carry_n` low while that pulse is in progress. `carry_n` returns high once the pulse ends, and the count wraps to zero.
- R5: A down pulse that starts while the count is zero drives `borrow_n` low while that pulse is in progress, and the count wraps to all ones.
- R6: While `cnt_clr` is high the count is held at zero and up pulses neither count nor carry. A down pulse during clear still produces a `borrow_n` pulse. After system reset the count, `data_out` and `collide_err` are zero and `carry_n` and `borrow_n` are high.
- R7: While `snap_stb` is high `data_out` follows the count. After `snap_stb` falls with no pulse in progress, `data_out` keeps the captured value through later counts until `snap_stb` rises again.
- R8: If `snap_stb` falls while a count pulse is in progress, the capture waits until that pulse has been counted, and `data_out` then holds the post-count value.
- R9: A clear that happens while a capture is waiting sets the captured value to zero. A clear that happens after a capture has completed leaves `data_out` unchanged.
- R10: `data_oe` is high exactly when `out_en_n` is low.
- R11: Two stages chained carry-to-up and borrow-to-down form a 2*CNT_W-bit counter that wraps from all zeros to all ones on a down pulse and back on an up pulse, carrying across the stage boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| cnt_up_n | input | 1 | Active-low increment pulse, counted on its rising edge |
| cnt_dn_n | input | 1 | Active-low decrement pulse, counted on its rising edge |
| cnt_clr | input | 1 | Active-high count clear, level sensitive |
| snap_stb | input | 1 | Snapshot strobe: high is transparent, low holds |
| out_en_n | input | 1 | Active-low data output enable |
| data_out | output | CNT_W | Latched count value |
| data_oe | output | 1 | High when `data_out` would drive the pads |
| carry_n | output | 1 | Active-low carry pulse to the next stage |
| borrow_n | output | 1 | Active-low borrow pulse to the next stage |
| collide_err | output | 1 | High while both count lines are low together |

## Verification
The assertions assume that each level on the count, clear and strobe lines lasts at least two system clocks. This lets the synchronizers pass every edge through, so an edge seen on the synchronized signals is an edge the source really made. They also assume that at most one count line starts a pulse at a time, except on purpose when both go low together. The bench drives every input on the falling clock edge and holds each level for three or more cycles. Up and down pulses never overlap, except in the single collision scenario, where both lines fall and rise together.

// File: rtl/ext_cnt_pkg.sv
package ext_cnt_pkg;

    // Control inputs after synchronization, packed so one synchronizer covers them all
    typedef struct packed {
        logic up_n;
        logic dn_n;
        logic clr;
        logic stb;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);

    // Idle levels: both count lines high, no clear, latch transparent
    localparam ctl_t CTL_IDLE = '{up_n: 1'b1, dn_n: 1'b1, clr: 1'b0, stb: 1'b1};

    typedef enum logic [1:0] {
        STEP_HOLD,
        STEP_INC,
        STEP_DEC,
        STEP_CLEAR
    } step_e;

    typedef struct packed {
        logic up_start;   // up line fell while down line idles
        logic up_end;     // up line rose after a clean pulse
        logic dn_start;
        logic dn_end;
        logic both_low;
    } edges_t;

    function automatic edges_t find_edges(input ctl_t now, input ctl_t was);
        edges_t e;
        e.up_start = was.up_n & ~now.up_n & now.dn_n;
        e.dn_start = was.dn_n & ~now.dn_n & now.up_n;
        e.up_end   = ~was.up_n & now.up_n & was.dn_n & now.dn_n;
        e.dn_end   = ~was.dn_n & now.dn_n & was.up_n & now.up_n;
        e.both_low = ~now.up_n & ~now.dn_n;
        return e;
    endfunction

    function automatic step_e pick_step(input edges_t e, input logic clr);
        if (clr)           return STEP_CLEAR;
        else if (e.up_end) return STEP_INC;
        else if (e.dn_end) return STEP_DEC;
        else               return STEP_HOLD;
    endfunction

endpackage

// File: rtl/ext_sync.sv
module ext_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [STAGES-1:0][W-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ext_count_core.sv
module ext_count_core
    import ext_cnt_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  ctl_t             cur,
    input  ctl_t             was,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] count_nx,
    output logic             busy,
    output logic             carry_n,
    output logic             borrow_n,
    output logic             collide_err
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    edges_t edg;
    step_e  step;
    logic   at_max;
    logic   at_zero;

    assign edg     = find_edges(cur, was);
    assign step    = pick_step(edg, cur.clr);
    assign at_max  = (count_q == CNT_MAX);
    assign at_zero = (count_q == '0);
    assign busy    = ~cur.up_n | ~cur.dn_n;

    always_comb begin
        unique case (step)
            STEP_CLEAR: count_nx = '0;
            STEP_INC:   count_nx = count_q + CNT_ONE;
            STEP_DEC:   count_nx = count_q - CNT_ONE;
            default:    count_nx = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else begin
            count_q <= count_nx;
        end
    end

    // Carry/borrow open at the start of a pulse that will wrap, close when the line returns high
    always_ff @(posedge clk) begin
        if (rst) begin
            carry_n <= 1'b1;
        end else if (cur.up_n) begin
            carry_n <= 1'b1;
        end else if (edg.up_start && at_max && !cur.clr) begin
            carry_n <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            borrow_n <= 1'b1;
        end else if (cur.dn_n) begin
            borrow_n <= 1'b1;
        end else if (edg.dn_start && (at_zero || cur.clr)) begin
            borrow_n <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            collide_err <= 1'b0;
        end else begin
            collide_err <= edg.both_low;
        end
    end

endmodule

// File: rtl/ext_snap_latch.sv
module ext_snap_latch #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic             busy,
    input  logic [CNT_W-1:0] count_nx,
    output logic             stb_hold,
    output logic [CNT_W-1:0] snap
);

    // stb_hold: internal strobe, set by the strobe, cleared only when no count is in progress
    always_ff @(posedge clk) begin
        if (rst) begin
            stb_hold <= 1'b1;
        end else if (stb) begin
            stb_hold <= 1'b1;
        end else if (!busy) begin
            stb_hold <= 1'b0;
        end
    end

    // Loading the next count value makes the closing edge capture the post-count value
    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (stb_hold) begin
            snap <= count_nx;
        end
    end

endmodule

// File: rtl/ext_updown_stage.sv
module ext_updown_stage
    import ext_cnt_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cnt_up_n,
    input  logic             cnt_dn_n,
    input  logic             cnt_clr,
    input  logic             snap_stb,
    input  logic             out_en_n,
    output logic [CNT_W-1:0] data_out,
    output logic             data_oe,
    output logic             carry_n,
    output logic             borrow_n,
    output logic             collide_err
);

    ctl_t             ctl_raw;
    ctl_t             ctl_s;
    ctl_t             ctl_p;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;
    logic             cnt_busy;
    logic             stb_hold;
    logic [CNT_W-1:0] snap_q;
    logic             s_up_n;
    logic             s_dn_n;
    logic             s_clr;

    assign ctl_raw = '{up_n: cnt_up_n, dn_n: cnt_dn_n, clr: cnt_clr, stb: snap_stb};

    ext_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (CTL_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ctl_raw),
        .q   (ctl_s)
    );

    // One more register gives the previous synchronized value for edge detection
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_p <= CTL_IDLE;
        end else begin
            ctl_p <= ctl_s;
        end
    end

    assign s_up_n = ctl_s.up_n;
    assign s_dn_n = ctl_s.dn_n;
    assign s_clr  = ctl_s.clr;

    ext_count_core #(
        .CNT_W (CNT_W)
    ) u_core (
        .clk         (clk),
        .rst         (rst),
        .cur         (ctl_s),
        .was         (ctl_p),
        .count_q     (cnt_q),
        .count_nx    (cnt_nx),
        .busy        (cnt_busy),
        .carry_n     (carry_n),
        .borrow_n    (borrow_n),
        .collide_err (collide_err)
    );

    ext_snap_latch #(
        .CNT_W (CNT_W)
    ) u_latch (
        .clk      (clk),
        .rst      (rst),
        .stb      (ctl_s.stb),
        .busy     (cnt_busy),
        .count_nx (cnt_nx),
        .stb_hold (stb_hold),
        .snap     (snap_q)
    );

    assign data_out = snap_q;
    assign data_oe  = ~out_en_n;

endmodule

// File: rtl/ext_updown_chk.sv
module ext_updown_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             s_up_n,
    input logic             s_dn_n,
    input logic             s_clr,
    input logic [CNT_W-1:0] cnt_q,
    input logic             stb_hold,
    input logic [CNT_W-1:0] snap_q,
    input logic             carry_n,
    input logic             borrow_n,
    input logic             collide_err
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    AST_INC_STEP: assert property (@(posedge clk) disable iff (rst)
        ($rose(s_up_n) && s_dn_n && $past(s_dn_n) && !s_clr) |=> (cnt_q == $past(cnt_q) + CNT_ONE)); // R1

    AST_DEC_STEP: assert property (@(posedge clk) disable iff (rst)
        ($rose(s_dn_n) && s_up_n && $past(s_up_n) && !s_clr) |=> (cnt_q == $past(cnt_q) - CNT_ONE)); // R2

    AST_COLLIDE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!s_up_n && !s_dn_n && !s_clr) |=> $stable(cnt_q)); // R3

    AST_COLLIDE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (!s_up_n && !s_dn_n) |=> collide_err); // R3

    AST_CARRY_FROM_MAX: assert property (@(posedge clk) disable iff (rst)
        $fell(carry_n) |-> ($past(cnt_q) == CNT_MAX)); // R4

    AST_CARRY_RELEASE: assert property (@(posedge clk) disable iff (rst)
        s_up_n |=> carry_n); // R4

    AST_BORROW_FROM_ZERO: assert property (@(posedge clk) disable iff (rst)
        $fell(borrow_n) |-> (($past(cnt_q) == '0) || $past(s_clr))); // R5

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
        s_clr |=> (cnt_q == '0)); // R6

    AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb_hold |=> $stable(snap_q)); // R7

endmodule

bind ext_updown_stage ext_updown_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .s_up_n      (s_up_n),
    .s_dn_n      (s_dn_n),
    .s_clr       (s_clr),
    .cnt_q       (cnt_q),
    .stb_hold    (stb_hold),
    .snap_q      (snap_q),
    .carry_n     (carry_n),
    .borrow_n    (borrow_n),
    .collide_err (collide_err)
);

// File: tb/tb_ext_updown_stage.sv
module tb_ext_updown_stage;

    localparam int W = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic up_n = 1'b1;
    logic dn_n = 1'b1;
    logic clr = 1'b0;
    logic stb = 1'b1;
    logic oe_n = 1'b1;

    logic [W-1:0] lo_data, hi_data;
    logic lo_oe, hi_oe, lo_carry, hi_carry, lo_borrow, hi_borrow, lo_err, hi_err;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit seen_lo_carry, seen_lo_borrow, seen_hi_carry, seen_hi_borrow;

    always #5 clk = ~clk;

    ext_updown_stage #(.CNT_W(W), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst(rst), .cnt_up_n(up_n), .cnt_dn_n(dn_n), .cnt_clr(clr),
        .snap_stb(stb), .out_en_n(oe_n), .data_out(lo_data), .data_oe(lo_oe),
        .carry_n(lo_carry), .borrow_n(lo_borrow), .collide_err(lo_err)
    );

    ext_updown_stage #(.CNT_W(W), .SYNC_STAGES(2)) u_hi (
        .clk(clk), .rst(rst), .cnt_up_n(lo_carry), .cnt_dn_n(lo_borrow), .cnt_clr(clr),
        .snap_stb(stb), .out_en_n(oe_n), .data_out(hi_data), .data_oe(hi_oe),
        .carry_n(hi_carry), .borrow_n(hi_borrow), .collide_err(hi_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic sample_flags();
        if (!lo_carry)  seen_lo_carry  = 1;
        if (!lo_borrow) seen_lo_borrow = 1;
        if (!hi_carry)  seen_hi_carry  = 1;
        if (!hi_borrow) seen_hi_borrow = 1;
    endtask

    // One count pulse on the up or down line, watching carry/borrow throughout
    task automatic pulse(input bit is_up, input int low_cycles);
        seen_lo_carry = 0; seen_lo_borrow = 0; seen_hi_carry = 0; seen_hi_borrow = 0;
        @(negedge clk);
        if (is_up) up_n = 1'b0; else dn_n = 1'b0;
        for (int i = 0; i < low_cycles; i++) begin
            @(negedge clk);
            sample_flags();
        end
        if (is_up) up_n = 1'b1; else dn_n = 1'b1;
        for (int i = 0; i < 14; i++) begin
            @(negedge clk);
            sample_flags();
        end
    endtask

    task automatic do_clear();
        @(negedge clk);
        clr = 1'b1;
        wait_n(5);
        clr = 1'b0;
        wait_n(5);
    endtask

    task automatic t_reset_state();
        chk("R6 reset data", int'(lo_data), 0);
        chk("R6 reset carry", int'(lo_carry), 1);
        chk("R6 reset borrow", int'(lo_borrow), 1);
        chk("R6 reset err", int'(lo_err), 0);
    endtask

    task automatic t_up_down();
        for (int i = 0; i < 3; i++) pulse(1, 4);
        chk("R1 three ups", int'(lo_data), 3);
        chk("R1 no carry", int'(seen_lo_carry), 0);
        pulse(0, 4);
        chk("R2 one down", int'(lo_data), 2);
        chk("R2 no borrow", int'(seen_lo_borrow), 0);
    endtask

    task automatic t_out_enable();
        @(negedge clk); oe_n = 1'b0;
        @(negedge clk);
        chk("R10 enabled", int'(lo_oe), 1);
        oe_n = 1'b1;
        @(negedge clk);
        chk("R10 disabled", int'(lo_oe), 0);
    endtask

    task automatic t_collide();
        @(negedge clk);
        up_n = 1'b0; dn_n = 1'b0;
        wait_n(6);
        chk("R3 err flag", int'(lo_err), 1);
        up_n = 1'b1; dn_n = 1'b1;
        wait_n(10);
        chk("R3 no count", int'(lo_data), 2);
        chk("R3 err cleared", int'(lo_err), 0);
    endtask

    task automatic t_wrap();
        do_clear();
        pulse(0, 4);
        chk("R5 borrow seen", int'(seen_lo_borrow), 1);
        chk("R5 wrap to max", int'(lo_data), 8'hFF);
        chk("R5 borrow released", int'(lo_borrow), 1);
        pulse(1, 4);
        chk("R4 carry seen", int'(seen_lo_carry), 1);
        chk("R4 wrap to zero", int'(lo_data), 0);
        chk("R4 carry released", int'(lo_carry), 1);
    endtask

    task automatic t_clear();
        pulse(1, 4); pulse(1, 4);
        chk("R1 before clear", int'(lo_data), 2);
        @(negedge clk); clr = 1'b1;
        wait_n(5);
        chk("R6 cleared", int'(lo_data), 0);
        pulse(1, 4);
        chk("R6 up ignored", int'(lo_data), 0);
        chk("R6 no carry", int'(seen_lo_carry), 0);
        pulse(0, 4);
        chk("R6 borrow in clear", int'(seen_lo_borrow), 1);
        chk("R6 stays zero", int'(lo_data), 0);
        clr = 1'b0;
        wait_n(5);
    endtask

    task automatic t_hold();
        pulse(1, 4);
        @(negedge clk); stb = 1'b0;
        wait_n(5);
        pulse(1, 4); pulse(1, 4);
        chk("R7 held", int'(lo_data), 1);
        stb = 1'b1;
        wait_n(5);
        chk("R7 transparent", int'(lo_data), 3);
    endtask

    task automatic t_pending();
        @(negedge clk); up_n = 1'b0;
        wait_n(3);
        stb = 1'b0;
        wait_n(4);
        up_n = 1'b1;
        wait_n(10);
        chk("R8 post-count captured", int'(lo_data), 4);
        pulse(1, 4);
        chk("R8 held after", int'(lo_data), 4);
        stb = 1'b1;
        wait_n(5);
        chk("R8 reopen", int'(lo_data), 5);
    endtask

    task automatic t_pending_clear();
        @(negedge clk); stb = 1'b0;
        wait_n(5);
        do_clear();
        chk("R9 completed capture kept", int'(lo_data), 5);
        stb = 1'b1;
        wait_n(5);
        chk("R9 reopen after clear", int'(lo_data), 0);
        pulse(1, 4); pulse(1, 4);
        @(negedge clk); up_n = 1'b0;
        wait_n(3);
        stb = 1'b0;
        wait_n(3);
        clr = 1'b1;
        wait_n(4);
        up_n = 1'b1;
        wait_n(10);
        clr = 1'b0;
        wait_n(5);
        chk("R9 waiting capture cleared", int'(lo_data), 0);
        pulse(1, 4);
        chk("R9 still held", int'(lo_data), 0);
        stb = 1'b1;
        wait_n(5);
        chk("R9 count after", int'(lo_data), 1);
    endtask

    task automatic t_chain();
        do_clear();
        pulse(0, 4);
        chk("R11 16-bit down wrap", int'({hi_data, lo_data}), 16'hFFFF);
        chk("R11 upper borrow", int'(seen_hi_borrow), 1);
        pulse(1, 4);
        chk("R11 16-bit up wrap", int'({hi_data, lo_data}), 16'h0000);
        chk("R11 upper carry", int'(seen_hi_carry), 1);
        for (int i = 0; i < 256; i++) pulse(1, 3);
        chk("R11 carry into upper", int'({hi_data, lo_data}), 16'h0100);
        pulse(0, 3);
        chk("R11 borrow from upper", int'({hi_data, lo_data}), 16'h00FF);
    endtask

    initial begin
        wait_n(5);
        rst = 1'b0;
        wait_n(5);
        t_reset_state();
        t_up_down();
        t_out_enable();
        t_collide();
        t_wrap();
        t_clear();
        t_hold();
        t_pending();
        t_pending_clear();
        t_chain();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule